// File: doc/BRIEF.md
# Instruction-Embedded I/O Select Decoder

This block sits beside a small 8-bit microcontroller whose control store is 24 bits wide. The low 16 bits carry the ordinary instruction. The top 8 bits are an I/O select byte, and the block decodes it in the same cycle the instruction runs. No separate select instruction is needed, so one instruction can move a byte to or from a peripheral register. The two upper bits of the same byte also carry a DRAM control code.

On the left I/O bank, the low six bits of the select byte pick one of three targets. These are eight load strobes toward external write-side registers, eight enable strobes toward external read-side registers, or one entry of a 16-byte scratch pad. The scratch pad is held inside the block. The right bank carries DRAM data, and for it only the memory-control code matters. The select byte is captured once, at the start of each instruction cycle. Every strobe decodes from that captured copy.

The interfaces are cycle-locked buses that follow the microcontroller's timing. There is no valid/ready pair and no back-pressure. Every strobe is a single-cycle qualifier, and the core must present the read or write cycle while the captured select is current.

Top module: `iosel_decoder`

## Requirements
- R1: The select byte is captured at a rising clock edge where `cyc_start` is high. Every output decodes from the captured copy, so changes on `sel_byte` while `cyc_start` is low have no effect.
- R2: `port_ld[k]` (k = 0..7) is high exactly when `left_bank` and `wr_cyc` are both high and the captured bits 5:0 equal k.
- R3: `port_en[k]` (k = 0..7) is high exactly when `left_bank` and `rd_cyc` are both high and the captured bits 5:0 equal 8+k.
- R4: When `left_bank` and `rd_cyc` are high and the captured bits 5:0 lie in 0x10..0x1F, `io_doe` is high and `io_dout` shows scratch entry bits 3:0. In every other case `io_doe` is low and `io_dout` is zero.
- R5: At a rising edge where `left_bank` and `wr_cyc` are high and the captured bits 5:0 lie in 0x30..0x3F, scratch entry bits 3:0 takes `io_din`. No other entry changes.
- R6: Captured bits 5:0 in 0x20..0x2F assert no strobe and write no scratch entry. With `left_bank` low, no port strobe, no scratch read and no scratch write occurs.
- R7: The captured bits 7:6 drive the memory-control outputs: 01 gives `mem_rd`, 10 gives `mem_wr`, 11 gives `mem_rfsh`, and 00 gives none. These outputs do not depend on the bank or on the cycle strobes, so at most one is high.
- R8: In any cycle, at most one of the sixteen port strobes, the scratch read and the scratch write is active, even with `rd_cyc` and `wr_cyc` both high.
- R9: After reset the captured select is 0x20, so no strobe or memory control is active, and all scratch entries read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Instruction-cycle start; captures `sel_byte` |
| sel_byte | input | 8 | Top byte of the control-store word |
| left_bank | input | 1 | High for the register/scratch bank, low for the DRAM bank |
| rd_cyc | input | 1 | Read cycle of the I/O bus |
| wr_cyc | input | 1 | Write-cycle strobe of the I/O bus |
| io_din | input | 8 | I/O data bus toward the block |
| io_dout | output | 8 | Scratch read data, zero when not driving |
| io_doe | output | 1 | Output enable for `io_dout` (tristate control) |
| port_ld | output | 8 | Load strobes for the write-side registers (select 0x00..0x07) |
| port_en | output | 8 | Enable strobes for the read-side registers (select 0x08..0x0F) |
| mem_rd | output | 1 | DRAM read control |
| mem_wr | output | 1 | DRAM write control |
| mem_rfsh | output | 1 | DRAM refresh control |

## Verification
A memory-control code and a left-bank port or scratch access can be active in the same cycle, because they come from disjoint bits of one select byte. The bench provokes this by sweeping all 256 select values in both banks with four read/write strobe combinations. In every cycle it checks, from the select value alone, both the memory-control output and the strobe or scratch result. It also changes the select input during each cycle, which shows that the captured copy, not the live input, drives both functions. It counts active strobes to confirm they stay mutually exclusive.

// File: rtl/iosel_pkg.sv
package iosel_pkg;

  localparam int unsigned SEL_W  = 8;
  localparam int unsigned FIELD_W = 6;
  localparam logic [SEL_W-1:0] SEL_IDLE = 8'h20;

  typedef enum logic [1:0] {
    MC_NONE    = 2'b00,
    MC_READ    = 2'b01,
    MC_WRITE   = 2'b10,
    MC_REFRESH = 2'b11
  } memctl_e;

  typedef enum logic [2:0] {
    CLS_LOAD   = 3'd0,
    CLS_ENABLE = 3'd1,
    CLS_SP_RD  = 3'd2,
    CLS_NONE   = 3'd3,
    CLS_SP_WR  = 3'd4
  } sel_class_e;

  function automatic sel_class_e classify(input logic [FIELD_W-1:0] f);
    sel_class_e c;
    unique case (f[5:4])
      2'b00:   c = f[3] ? CLS_ENABLE : CLS_LOAD;
      2'b01:   c = CLS_SP_RD;
      2'b10:   c = CLS_NONE;
      default: c = CLS_SP_WR;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/iosel_latch.sv
module iosel_latch #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RESET_VAL;
    else if (cap) q <= d;
  end

endmodule

// File: rtl/iosel_port_dec.sv
module iosel_port_dec
  import iosel_pkg::*;
#(
  parameter int unsigned PORT_N = 8
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               left_bank,
  input  logic               rd_cyc,
  input  logic               wr_cyc,
  output logic [PORT_N-1:0]  port_ld,
  output logic [PORT_N-1:0]  port_en,
  output logic               sp_rd,
  output logic               sp_we
);

  localparam int unsigned PORT_AW = $clog2(PORT_N);

  sel_class_e cls;
  logic       lb_rd;
  logic       lb_wr;

  assign cls   = classify(field);
  assign lb_rd = left_bank & rd_cyc;
  assign lb_wr = left_bank & wr_cyc;

  for (genvar k = 0; k < PORT_N; k++) begin : g_port
    logic hit;
    assign hit        = (field[PORT_AW-1:0] == PORT_AW'(k));
    assign port_ld[k] = lb_wr && (cls == CLS_LOAD)   && hit;
    assign port_en[k] = lb_rd && (cls == CLS_ENABLE) && hit;
  end

  assign sp_rd = lb_rd && (cls == CLS_SP_RD);
  assign sp_we = lb_wr && (cls == CLS_SP_WR);

endmodule

// File: rtl/iosel_scratch.sv
module iosel_scratch #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SP_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [$clog2(SP_DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        rd,
  input  logic [$clog2(SP_DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]           rdata,
  output logic                        oe
);

  localparam int unsigned AW = $clog2(SP_DEPTH);

  logic [DATA_W-1:0] ent_view [SP_DEPTH];

  for (genvar e = 0; e < SP_DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ent_q <= '0;
      else if (we && (waddr == AW'(e)))   ent_q <= wdata;
    end
    assign ent_view[e] = ent_q;
  end

  assign rdata = rd ? ent_view[raddr] : '0;
  assign oe    = rd;

endmodule

// File: rtl/iosel_memctl.sv
module iosel_memctl
  import iosel_pkg::*;
(
  input  logic [1:0] code,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       mem_rfsh
);

  memctl_e mc;
  assign mc = memctl_e'(code);

  always_comb begin
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    mem_rfsh = 1'b0;
    unique case (mc)
      MC_READ:    mem_rd   = 1'b1;
      MC_WRITE:   mem_wr   = 1'b1;
      MC_REFRESH: mem_rfsh = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/iosel_decoder.sv
module iosel_decoder
  import iosel_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PORT_N   = 8,
  parameter int unsigned SP_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [7:0]        sel_byte,
  input  logic              left_bank,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  input  logic [DATA_W-1:0] io_din,
  output logic [DATA_W-1:0] io_dout,
  output logic              io_doe,
  output logic [PORT_N-1:0] port_ld,
  output logic [PORT_N-1:0] port_en,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_rfsh
);

  localparam int unsigned SP_AW = $clog2(SP_DEPTH);

  logic [SEL_W-1:0] sel_q;
  logic             sp_rd;
  logic             sp_we;

  iosel_latch #(.W(SEL_W), .RESET_VAL(SEL_IDLE)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cyc_start),
    .d     (sel_byte),
    .q     (sel_q)
  );

  iosel_port_dec #(.PORT_N(PORT_N)) u_dec (
    .field     (sel_q[FIELD_W-1:0]),
    .left_bank (left_bank),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .port_ld   (port_ld),
    .port_en   (port_en),
    .sp_rd     (sp_rd),
    .sp_we     (sp_we)
  );

  iosel_scratch #(.DATA_W(DATA_W), .SP_DEPTH(SP_DEPTH)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sp_we),
    .waddr (sel_q[SP_AW-1:0]),
    .wdata (io_din),
    .rd    (sp_rd),
    .raddr (sel_q[SP_AW-1:0]),
    .rdata (io_dout),
    .oe    (io_doe)
  );

  iosel_memctl u_mc (
    .code     (sel_q[SEL_W-1 -: 2]),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_rfsh (mem_rfsh)
  );

endmodule

// File: rtl/iosel_decoder_chk.sv
module iosel_decoder_chk #(
  parameter int unsigned PORT_N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              left_bank,
  input logic              rd_cyc,
  input logic              wr_cyc,
  input logic              io_doe,
  input logic [PORT_N-1:0] port_ld,
  input logic [PORT_N-1:0] port_en,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_rfsh,
  input logic              sp_we
);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({port_ld, port_en, io_doe, sp_we}) <= 1);

  // R7
  memctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, mem_rfsh}));

  // R2
  ld_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_ld) |-> (wr_cyc && left_bank));

  // R3
  en_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_en) |-> (rd_cyc && left_bank));

  // R4
  doe_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_doe |-> (rd_cyc && left_bank));

  // R5
  spwe_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (wr_cyc && left_bank));

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable({mem_rd, mem_wr, mem_rfsh}));

endmodule

bind iosel_decoder iosel_decoder_chk #(.PORT_N(PORT_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .left_bank (left_bank),
  .rd_cyc    (rd_cyc),
  .wr_cyc    (wr_cyc),
  .io_doe    (io_doe),
  .port_ld   (port_ld),
  .port_en   (port_en),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_rfsh  (mem_rfsh),
  .sp_we     (sp_we)
);

// File: tb/sim_iosel_decoder.sv
module sim_iosel_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic [7:0] sel_byte = 8'h00;
  logic       left_bank = 1'b0;
  logic       rd_cyc = 1'b0;
  logic       wr_cyc = 1'b0;
  logic [7:0] io_din = 8'h00;
  logic [7:0] io_dout;
  logic       io_doe;
  logic [7:0] port_ld;
  logic [7:0] port_en;
  logic       mem_rd;
  logic       mem_wr;
  logic       mem_rfsh;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_sp [16];

  always #2.5 clk = ~clk;

  iosel_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .sel_byte(sel_byte),
    .left_bank(left_bank), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .io_din(io_din),
    .io_dout(io_dout), .io_doe(io_doe), .port_ld(port_ld), .port_en(port_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rfsh(mem_rfsh)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic run_op(input logic [7:0] sel, input logic lb, input logic rd,
                        input logic wr, input logic [7:0] din);
    logic [5:0] f;
    logic [7:0] e_ld, e_en, e_dout;
    logic       e_doe, e_we;
    string      t_ld, t_en, t_rd;
    f = sel[5:0];
    @(negedge clk);
    sel_byte = sel; cyc_start = 1'b1;
    left_bank = 1'b0; rd_cyc = 1'b0; wr_cyc = 1'b0;
    @(negedge clk);
    cyc_start = 1'b0; sel_byte = ~sel;  // R1: live input changes after capture
    left_bank = lb; rd_cyc = rd; wr_cyc = wr; io_din = din;
    #1;
    e_ld   = (lb && wr && f[5:3] == 3'b000) ? 8'(1 << f[2:0]) : 8'h00;
    e_en   = (lb && rd && f[5:3] == 3'b001) ? 8'(1 << f[2:0]) : 8'h00;
    e_doe  = lb && rd && (f[5:4] == 2'b01);
    e_dout = e_doe ? model_sp[f[3:0]] : 8'h00;
    e_we   = lb && wr && (f[5:4] == 2'b11);
    t_ld = (!lb || f[5:4] == 2'b10) ? "R6 port_ld" : "R2 port_ld";
    t_en = (!lb || f[5:4] == 2'b10) ? "R6 port_en" : "R3 port_en";
    t_rd = (!lb || f[5:4] == 2'b10) ? "R6 scratch read" : "R4 scratch read";
    chk(t_ld, {8'h0, port_ld}, {8'h0, e_ld});
    chk(t_en, {8'h0, port_en}, {8'h0, e_en});
    chk(t_rd, {7'h0, io_doe, io_dout}, {7'h0, e_doe, e_dout});
    chk("R1/R7 memory control", {13'h0, mem_rd, mem_wr, mem_rfsh},
        {13'h0, sel[7:6] == 2'b01, sel[7:6] == 2'b10, sel[7:6] == 2'b11});
    chk("R8 strobe count", 16'($countones({port_ld, port_en, io_doe})), 16'(e_ld != 0 || e_en != 0 || e_doe));
    if (e_we) model_sp[f[3:0]] = din;  // R5: commits at the next rising edge
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) model_sp[i] = 8'h00;
    left_bank = 1'b1; rd_cyc = 1'b1; wr_cyc = 1'b1;
    #12;
    // R9: reset state with all qualifiers high
    chk("R9 reset port_ld", {8'h0, port_ld}, 16'h0);
    chk("R9 reset port_en", {8'h0, port_en}, 16'h0);
    chk("R9 reset doe", {15'h0, io_doe}, 16'h0);
    chk("R9 reset memctl", {13'h0, mem_rd, mem_wr, mem_rfsh}, 16'h0);
    rst_n = 1'b1;
    left_bank = 1'b0; rd_cyc = 1'b0; wr_cyc = 1'b0;
    // R9: scratch reads zero after reset
    for (int i = 0; i < 16; i++) run_op(8'h10 | 8'(i), 1'b1, 1'b1, 1'b0, 8'h00);
    // Full sweep: select x bank x strobe combination
    for (int s = 0; s < 256; s++)
      for (int b = 0; b < 2; b++)
        for (int m = 0; m < 4; m++)
          run_op(8'(s), b[0], m[0], m[1], 8'(s * 7 + m * 31 + b * 3 + 1));
    // R5: final readback of every scratch entry against the model
    for (int i = 0; i < 16; i++) run_op(8'h50 | 8'(i), 1'b1, 1'b1, 1'b0, 8'h00);
    // R5: single write then neighbour check
    run_op(8'h35, 1'b1, 1'b0, 1'b1, 8'hA6);
    run_op(8'h15, 1'b1, 1'b1, 1'b0, 8'h00);
    run_op(8'h16, 1'b1, 1'b1, 1'b0, 8'h00);
    // R6: right-bank write to a scratch select leaves the entry intact
    run_op(8'hB5, 1'b0, 1'b0, 1'b1, 8'h11);
    run_op(8'hD5, 1'b1, 1'b1, 1'b0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule